// File: doc/BRIEF.md
# March-Test Built-In Self-Test Controller

This block drives a synchronous single-port RAM through a march test. It generates the address, write data, write enable and read enable. It compares every word read back against the value it expects. It reports the outcome with a sticky fail flag and with the address, march number and data of the first mismatch. A one-cycle `start` pulse launches a run, and a one-cycle `done` pulse marks its end.

Two inputs are sampled when a run is accepted. The first chooses between two sequences. The short sequence has three marches: write the background, then read-check and write the inverse, then read-check and write the background. The long sequence has five marches: it adds a read-only pass that checks the background before the second march, and a read-only pass that checks the inverse before the third. The second input chooses the data pattern. A solid pattern uses all zeros and all ones. An alternating-bit pattern exposes shorts between neighbouring bits of the same word.

The RAM must return read data one clock after the address is presented. The controller compares that data in the following cycle, and then writes the same address in that same cycle.

Top module: `mbist_march_ctrl`

## Requirements
- R1: While `rst_n` is low, and after reset, `busy`, `done`, `fail`, `mem_we` and `mem_re` are 0.
- R2: The short mode runs 3 marches, indexed 0..2. The long mode runs 5 marches, indexed 0..4. A write-only march takes 1 cycle per address, and every march that reads takes 2 cycles per address. `busy` is therefore high for exactly 5*DEPTH cycles (short mode) or 9*DEPTH cycles (long mode) after the start edge.
- R3: In every march the address walks upward from 0 to DEPTH-1. Across a run, the k-th write (counting from 0) and the k-th read both go to address k mod DEPTH.
- R4: Read data is taken one cycle after `mem_re`, at the same address. Any write to that address happens in that compare cycle, so the write comes after the check.
- R5: In solid mode the background is all zeros and its inverse is all ones. After a fault-free short run, every location holds the background.
- R6: In alternating mode, background bit i is 1 for even i and 0 for odd i (0x55 for 8 bits), and the inverse is the complement (0xAA). After a fault-free short run, every location holds 0x55.
- R7: On the first mismatch, `fail_addr` takes the address, `fail_march` the march index, and `fail_data` the word as read. Later mismatches do not change these values.
- R8: Once set, `fail` stays high to the end of the run and after it. The run always completes. `fail` and the capture registers clear only when the next start is accepted.
- R9: `done` is high for exactly one cycle: the first cycle in which `busy` is low after a run.
- R10: `start`, `long_mode` and `alt_pattern` are ignored while `busy` is high. The mode and pattern are sampled only with an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch a run (accepted only when idle) |
| long_mode | input | 1 | 1 selects the five-march sequence |
| alt_pattern | input | 1 | 1 selects alternating-bit backgrounds |
| mem_addr | output | ADDR_W | RAM address |
| mem_wdata | output | DATA_W | RAM write data |
| mem_we | output | 1 | RAM write enable |
| mem_re | output | 1 | RAM read enable |
| mem_rdata | input | DATA_W | RAM read data, valid one cycle after `mem_re` |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_march | output | 3 | March index of the first mismatch |
| fail_data | output | DATA_W | Word read at the first mismatch |

## Verification
The assertions watch, on every cycle:
- that each read is followed by a compare cycle at the same address,
- that `done` lasts one cycle and finds the block idle,
- that the latched mode stays unchanged when `start` arrives during a run,
- that the address counter never steps past the last location,
- that the march index stays in range,
- that a set fail flag and its captured address hold until the next accepted start.

Only the bench scenarios can show the rest:
- the total run length,
- the ascending write and read address order,
- the memory contents a run leaves behind,
- the exact first-failure values produced by a stuck bit or a short between neighbouring bits, in each mode and pattern.

// File: rtl/mbist_pkg.sv
// Package: shared state encoding, march-step decode and sequence length
// for the march-test controller. Assumes at most 8 marches (3-bit index).
package mbist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WR   = 3'd1,
        ST_RD   = 3'd2,
        ST_CHK  = 3'd3,
        ST_DONE = 3'd4
    } seq_state_t;

    typedef struct packed {
        logic do_read;
        logic do_write;
        logic exp_inv;
        logic wr_inv;
    } march_op_t;

    // Decode what march idx does in the selected sequence
    function automatic march_op_t march_op(input logic long_m, input logic [2:0] idx);
        march_op_t op;
        op = '0;
        if (!long_m) begin
            case (idx)
                3'd0: begin op.do_write = 1'b1; end
                3'd1: begin op.do_read = 1'b1; op.do_write = 1'b1; op.wr_inv = 1'b1; end
                default: begin op.do_read = 1'b1; op.do_write = 1'b1; op.exp_inv = 1'b1; end
            endcase
        end else begin
            case (idx)
                3'd0: begin op.do_write = 1'b1; end
                3'd1: begin op.do_read = 1'b1; end
                3'd2: begin op.do_read = 1'b1; op.do_write = 1'b1; op.wr_inv = 1'b1; end
                3'd3: begin op.do_read = 1'b1; op.exp_inv = 1'b1; end
                default: begin op.do_read = 1'b1; op.do_write = 1'b1; op.exp_inv = 1'b1; end
            endcase
        end
        return op;
    endfunction

    // Index of the final march in the selected sequence
    function automatic logic [2:0] last_march(input logic long_m);
        return long_m ? 3'd4 : 3'd2;
    endfunction

endpackage

// File: rtl/mbist_bg_gen.sv
// Background pattern generator: builds the solid or alternating-bit word,
// optionally inverted. Purely combinational; assumes DATA_W >= 1.
module mbist_bg_gen #(
    parameter int DATA_W = 8
) (
    input  logic              alt,
    input  logic              invert,
    output logic [DATA_W-1:0] pattern
);
    // One bit per lane: even lanes are 1 in alternating mode
    for (genvar i = 0; i < DATA_W; i++) begin : g_lane
        localparam logic EVEN_BIT = ((i % 2) == 0);
        assign pattern[i] = (alt & EVEN_BIT) ^ invert;
    end
endmodule

// File: rtl/mbist_addr_ctr.sv
// Ascending address counter over the full 2**ADDR_W space. Clear has
// priority over increment; at_last flags the top location.
module mbist_addr_ctr #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    // Address register: reset/clear to zero, step upward on inc
    always_ff @(posedge clk) begin
        if (!rst_n || clr) addr <= '0;
        else if (inc)      addr <= addr + 1'b1;
    end

    assign at_last = (addr == LAST_ADDR);

    // R3: the counter is never asked to step past the last location
    addr_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |-> !at_last);
endmodule

// File: rtl/mbist_seq.sv
// March sequencer: walks the selected march list, issuing one write cycle
// per address for write-only marches and a read cycle plus a compare
// cycle per address for marches that read. Mode inputs are latched on an
// accepted start and held for the whole run.
module mbist_seq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       long_in,
    input  logic       alt_in,
    input  logic       at_last,
    output logic       run_start,
    output logic       addr_clr,
    output logic       addr_inc,
    output logic       mem_we,
    output logic       mem_re,
    output logic       cmp_en,
    output logic       exp_inv,
    output logic       wr_inv,
    output logic       alt_q,
    output logic [2:0] march_idx,
    output logic       busy,
    output logic       done
);
    import mbist_pkg::*;

    seq_state_t state;
    logic       long_q;
    march_op_t  op;
    march_op_t  next_op;
    logic       step_done;
    logic       march_end;
    logic       run_end;

    assign op        = march_op(long_q, march_idx);
    assign next_op   = march_op(long_q, march_idx + 3'd1);
    assign run_start = (state == ST_IDLE) && start;
    assign step_done = (state == ST_WR) || (state == ST_CHK);
    assign march_end = step_done && at_last;
    assign run_end   = march_end && (march_idx == last_march(long_q));

    // Main state register: advance per address and per march
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            march_idx <= '0;
            long_q    <= 1'b0;
            alt_q     <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        long_q    <= long_in;
                        alt_q     <= alt_in;
                        march_idx <= '0;
                        state     <= ST_WR;
                    end
                end
                ST_WR, ST_CHK: begin
                    if (run_end) begin
                        state <= ST_DONE;
                    end else if (march_end) begin
                        march_idx <= march_idx + 3'd1;
                        state     <= next_op.do_read ? ST_RD : ST_WR;
                    end else begin
                        state <= op.do_read ? ST_RD : ST_WR;
                    end
                end
                ST_RD:   state <= ST_CHK;
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Memory and compare strobes decoded from the current step
    always_comb begin
        mem_re   = (state == ST_RD);
        cmp_en   = (state == ST_CHK);
        mem_we   = (state == ST_WR) || ((state == ST_CHK) && op.do_write);
        exp_inv  = op.exp_inv;
        wr_inv   = op.wr_inv;
        addr_clr = run_start || march_end;
        addr_inc = step_done && !at_last;
        busy     = (state == ST_WR) || (state == ST_RD) || (state == ST_CHK);
        done     = (state == ST_DONE);
    end

    // R4: every read is followed by a compare cycle with no new read
    rd_then_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> (cmp_en && !mem_re));

    // R9: done lasts one cycle and the block is idle meanwhile
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy ##1 !done));

    // R10: a start during a run leaves the latched modes unchanged
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(long_q) && $stable(alt_q)));

    // R2: the march index never exceeds the selected sequence length
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (march_idx <= last_march(long_q)));

    // R1: outputs idle in the cycle after reset
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && !mem_we && !mem_re));
endmodule

// File: rtl/mbist_cmp.sv
// Result capture: compares the read word with the expected background and
// keeps the first mismatch. Cleared only by an accepted start.
module mbist_cmp #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cmp_en,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] expected,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        march_idx,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [2:0]        fail_march,
    output logic [DATA_W-1:0] fail_data
);
    logic mismatch;
    assign mismatch = cmp_en && (rdata != expected);

    // First-failure capture with sticky flag
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            fail       <= 1'b0;
            fail_addr  <= '0;
            fail_march <= '0;
            fail_data  <= '0;
        end else if (mismatch && !fail) begin
            fail       <= 1'b1;
            fail_addr  <= addr;
            fail_march <= march_idx;
            fail_data  <= rdata;
        end
    end

    // R8: fail and the captured address hold until the next clear
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !clr) |=> (fail && $stable(fail_addr) && $stable(fail_march)));

    // R7: a new mismatch while already failed keeps the first record
    first_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && mismatch && !clr) |=> $stable(fail_data));
endmodule

// File: rtl/mbist_march_ctrl.sv
// Top level: march-test controller for a synchronous single-port RAM with
// one-cycle read latency. Tests all 2**ADDR_W locations of DATA_W bits.
module mbist_march_ctrl #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              long_mode,
    input  logic              alt_pattern,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [2:0]        fail_march,
    output logic [DATA_W-1:0] fail_data
);
    logic              run_start;
    logic              addr_clr;
    logic              addr_inc;
    logic              at_last;
    logic              cmp_en;
    logic              exp_inv;
    logic              wr_inv;
    logic              alt_q;
    logic [2:0]        march_idx;
    logic [DATA_W-1:0] exp_word;

    mbist_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .long_in   (long_mode),
        .alt_in    (alt_pattern),
        .at_last   (at_last),
        .run_start (run_start),
        .addr_clr  (addr_clr),
        .addr_inc  (addr_inc),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .cmp_en    (cmp_en),
        .exp_inv   (exp_inv),
        .wr_inv    (wr_inv),
        .alt_q     (alt_q),
        .march_idx (march_idx),
        .busy      (busy),
        .done      (done)
    );

    mbist_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (addr_clr),
        .inc     (addr_inc),
        .addr    (mem_addr),
        .at_last (at_last)
    );

    mbist_bg_gen #(.DATA_W(DATA_W)) u_wr_bg (
        .alt     (alt_q),
        .invert  (wr_inv),
        .pattern (mem_wdata)
    );

    mbist_bg_gen #(.DATA_W(DATA_W)) u_exp_bg (
        .alt     (alt_q),
        .invert  (exp_inv),
        .pattern (exp_word)
    );

    mbist_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (run_start),
        .cmp_en     (cmp_en),
        .rdata      (mem_rdata),
        .expected   (exp_word),
        .addr       (mem_addr),
        .march_idx  (march_idx),
        .fail       (fail),
        .fail_addr  (fail_addr),
        .fail_march (fail_march),
        .fail_data  (fail_data)
    );

    // R4: the compare cycle addresses the location that was just read
    cmp_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> $stable(mem_addr));
endmodule

// File: tb/sim_mbist_march_ctrl.sv
// Bench: RAM model with injectable stuck-bit and neighbour-short faults;
// every expectation below is derived by hand from the requirements.
module sim_mbist_march_ctrl;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          long_mode = 1'b0;
    logic          alt_pattern = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_we;
    logic          mem_re;
    logic [DW-1:0] mem_rdata;
    logic          busy;
    logic          done;
    logic          fail;
    logic [AW-1:0] fail_addr;
    logic [2:0]    fail_march;
    logic [DW-1:0] fail_data;

    always #2.5 clk = ~clk;

    mbist_march_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .long_mode(long_mode),
        .alt_pattern(alt_pattern), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata), .busy(busy),
        .done(done), .fail(fail), .fail_addr(fail_addr), .fail_march(fail_march),
        .fail_data(fail_data)
    );

    // fault_kind: 0 none, 1 stuck bit at one address, 2 AND-short of bits 1 and 2
    int            fault_kind = 0;
    int            f_addr = 0;
    int            f_bit = 0;
    logic          f_val = 1'b0;
    logic [DW-1:0] ram [N];
    int            wr_k = 0;
    int            rd_k = 0;
    int            ord_err = 0;

    function automatic logic [DW-1:0] faulty(input logic [DW-1:0] w, input int a);
        logic [DW-1:0] r;
        r = w;
        if (fault_kind == 1 && a == f_addr) r[f_bit] = f_val;
        if (fault_kind == 2) begin
            r[1] = w[1] & w[2];
            r[2] = w[1] & w[2];
        end
        return r;
    endfunction

    // RAM model with one-cycle read latency plus address-order monitor
    always @(posedge clk) begin
        if (mem_we) begin
            ram[mem_addr] <= faulty(mem_wdata, int'(mem_addr));
            if (int'(mem_addr) != wr_k % N) ord_err <= ord_err + 1;
            wr_k <= wr_k + 1;
        end
        if (mem_re) begin
            mem_rdata <= ram[mem_addr];
            if (int'(mem_addr) != rd_k % N) ord_err <= ord_err + 1;
            rd_k <= rd_k + 1;
        end
    end

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 0;

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Launch one run; optionally disturb start/modes mid-run; return busy length
    task automatic run(input logic lm, input logic ap, input bit disturb, output int cyc);
        @(negedge clk);
        wr_k = 0; rd_k = 0; ord_err = 0;
        start = 1'b1; long_mode = lm; alt_pattern = ap;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (busy && cyc < 5000) begin
            cyc++;
            if (disturb && cyc == 10) begin
                start = 1'b1; long_mode = ~lm; alt_pattern = ~ap;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check("R9 done high in first idle cycle", done, 1);
        @(negedge clk);
        check("R9 done lasts one cycle", done, 0);
    endtask

    function automatic bit all_hold(input logic [DW-1:0] v);
        for (int a = 0; a < N; a++) if (ram[a] != v) return 0;
        return 1;
    endfunction

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        check("R1 busy in reset", busy, 0);
        check("R1 we/re in reset", {mem_we, mem_re}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {busy, done, fail}, 0);

        // Clean short solid run
        run(1'b0, 1'b0, 1'b0, cyc);
        check("R2 short run length", cyc, 5 * N);
        check("R3 address order short", ord_err, 0);
        check("R5 memory left at solid background", all_hold(8'h00), 1);
        check("R7 no fail on clean RAM", fail, 0);

        // Clean long alternating run
        run(1'b1, 1'b1, 1'b0, cyc);
        check("R2 long run length", cyc, 9 * N);
        check("R3 address order long", ord_err, 0);
        check("R6 memory left at 0x55", all_hold(8'h55), 1);
        check("R7 no fail long alt", fail, 0);

        // Clean short alternating run leaves 0x55
        run(1'b0, 1'b1, 1'b0, cyc);
        check("R6 short alt leaves 0x55", all_hold(8'h55), 1);

        // Stuck-at-1 bit 0 at address 5: seen in march 1 reading 0x01
        fault_kind = 1; f_addr = 5; f_bit = 0; f_val = 1'b1;
        run(1'b0, 1'b0, 1'b0, cyc);
        check("R7 stuck1 fail", fail, 1);
        check("R7 stuck1 addr", fail_addr, 5);
        check("R7 stuck1 march", fail_march, 1);
        check("R7 stuck1 data", fail_data, 8'h01);

        // Stuck-at-0 bit 3 at address 9, short mode: march 2 reads 0xF7
        f_addr = 9; f_bit = 3; f_val = 1'b0;
        run(1'b0, 1'b0, 1'b0, cyc);
        check("R7 stuck0 short march", fail_march, 2);
        check("R7 stuck0 short addr", fail_addr, 9);
        check("R7 stuck0 short data", fail_data, 8'hF7);
        check("R8 run completes after fail", cyc, 5 * N);

        // Same fault, long mode: first seen by read-only march 3; march 4 also mismatches
        run(1'b1, 1'b0, 1'b0, cyc);
        check("R7 stuck0 long first march kept", fail_march, 3);
        check("R8 fail sticky after done", fail, 1);
        check("R8 long run completes", cyc, 9 * N);

        // Neighbour short: invisible with solid data, caught by alternating data
        fault_kind = 2;
        run(1'b0, 1'b0, 1'b0, cyc);
        check("R8 fail cleared by new start", fail, 0);
        run(1'b0, 1'b1, 1'b0, cyc);
        check("R6 short caught by alt", fail, 1);
        check("R6 short addr", fail_addr, 0);
        check("R6 short march", fail_march, 1);
        check("R6 short data", fail_data, 8'h51);

        // Start and mode changes during a run are ignored
        fault_kind = 0;
        run(1'b0, 1'b0, 1'b1, cyc);
        check("R10 length unchanged by mid-run start", cyc, 5 * N);
        check("R10 pattern unchanged by mid-run input", all_hold(8'h00), 1);
        check("R10 no stray run afterwards", busy, 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule